// File: doc/BRIEF.md
# Six-bit instruction sequencer core

This block is a small sequential processor that runs 6-bit instructions out of an 8-position active program store held outside the core. The top three bits of each word select the operation class and the low three bits select a register, adder mode, jump target or system command. The data path has three general registers (A, B, C), a counting register D, a spare register F and a transfer buffer through which all register-to-register traffic flows. Execution is strictly in order. It takes one instruction per clock, except where a handshake or a module load holds it.

Conditional flow has no flags and no conditional jump. A count or compare instruction decides whether the next instruction is skipped. Loops are built from a skip followed by an absolute jump. Program text can be swapped by asking an external loader for a numbered module. A status bit redirects buffer stores into the program store, which makes self-modifying boot code possible. Lever entry, tape reads and output strobes connect the core to its surroundings.

Top module: `seq6_core`

## Requirements
- R1: The word is {class[5:3], arg[2:0]}. Class 000 loads the buffer and class 001 stores the buffer. The arg codes are 000 = zero (load only), 001 = A, 010 = B, 011 = C, 100 = D and 110 = F. Args 101 and 111 leave the buffer and all registers unchanged.
- R2: Class 010 is the adder. Arg 001 puts A+B in C, 000 puts A+B in B, 100 copies A to B, 110 puts A XOR C in B, 010 puts B+C in B and 011 puts B+C in C. Sums wrap modulo 2^W.
- R3: Class 011 counts D: arg 100 increments and arg 101 decrements, modulo 2^W. When the new D is zero, the next instruction is skipped.
- R4: Class 100 compares without sign: arg 000 tests B>C and arg 011 tests A>B. The next instruction runs only when the test is true. Equal values count as false.
- R5: Class 101 jumps to program index arg. pm_addr carries the position minus one, 0..7.
- R6: Other instructions advance pm_addr by one, or by two on a skip, wrapping from 7 to 0. The code 111 011 is a no-operation.
- R7: Class 110 raises mod_req with mod_num = arg + 1 + 8*bank. Both stay stable, and the core fetches nothing, until mod_done is seen. Fetching then resumes at index 0.
- R8: Code 111 100 toggles the bank bit, which adds 8 to later module numbers.
- R9: Code 111 000 raises lev_ready and holds pm_addr until lev_valid. lev_data then enters the buffer.
- R10: Code 111 010 raises tape_ready and holds pm_addr until tape_valid. tape_data then enters the buffer.
- R11: Code 111 001 pulses out_valid for one cycle in the cycle after it executes. The pulse carries the buffer on out_data and the I/O status bit on out_alt. Code 111 111 toggles the I/O status bit.
- R12: Code 111 101 toggles a write-to-program bit. While it is set, a class 001 store writes buffer[5:0] into program index arg through pm_we, pm_waddr and pm_wdata, and leaves the register unchanged.
- R13: Code 111 110 sets halted. Halted stays set until reset, with no fetch advance, requests or writes.
- R14: After reset, pm_addr = 0, halted = 0, mod_req = 0 and out_valid = 0. All registers and status bits are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pm_addr | output | 3 | Program index being fetched |
| pm_word | input | 6 | Instruction word at pm_addr, same cycle |
| pm_we | output | 1 | Program store write strobe |
| pm_waddr | output | 3 | Program store write index |
| pm_wdata | output | 6 | Program store write data |
| mod_req | output | 1 | Module load request, held until mod_done |
| mod_num | output | 5 | Requested module number |
| mod_done | input | 1 | Loader finished |
| lev_ready | output | 1 | Core waits for lever entry |
| lev_valid | input | 1 | Lever value present |
| lev_data | input | W | Lever value |
| tape_ready | output | 1 | Core waits for a tape datum |
| tape_valid | input | 1 | Tape datum present |
| tape_data | input | W | Tape datum |
| out_valid | output | 1 | One-cycle output strobe |
| out_data | output | W | Buffer value sent out |
| out_alt | output | 1 | I/O status bit sent with the strobe |
| halted | output | 1 | Core is stopped |

## Verification
The bench targets the boundaries of the skip rule. These are a decrement that reaches zero, an increment that wraps from 63, and a compare of equal operands. A core that skips on the wrong sense or on a non-strict compare would leave a register it should have written, so the output shows the wrong value. Modular sums are checked through adder results that overflow, and the XOR and copy modes are checked in a single chain. Decoding these modes wrongly gives a different value. Other checks cover the cycles where the core must hold its position: waiting on the lever or tape, and waiting for a module load. A design that moved on early would run past the input or fetch stale words. The module number is also checked with the bank bit set. A redirected store must rewrite the program store and leave C alone. A halt must stay in force, which rules out running on or wrapping after it.

// File: rtl/seq6_pkg.sv
// Shared encodings for the six-bit sequencer core.
// Assumes instruction words are always six bits with a 3-bit class field.
package seq6_pkg;
    localparam int IW = 6;   // instruction width
    localparam int PW = 3;   // program index width (8 positions)
    localparam int MW = 5;   // module number width (1..16)

    typedef enum logic [2:0] {
        CL_LOAD  = 3'b000,
        CL_STORE = 3'b001,
        CL_ADD   = 3'b010,
        CL_CNT   = 3'b011,
        CL_CMP   = 3'b100,
        CL_JMP   = 3'b101,
        CL_MOD   = 3'b110,
        CL_SYS   = 3'b111
    } cls_e;

    typedef enum logic [2:0] {
        AF_NONE = 3'd0,
        AF_AB   = 3'd1,
        AF_PASS = 3'd2,
        AF_XOR  = 3'd3,
        AF_BC   = 3'd4
    } add_fn_e;

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_MODW = 2'd1,
        ST_HALT = 2'd2
    } state_e;
endpackage

// File: rtl/seq6_decode.sv
// Instruction decoder: turns one six-bit word into datapath and flow controls.
// Purely combinational; undefined argument codes decode to no action.
module seq6_decode
    import seq6_pkg::*;
(
    input  logic [IW-1:0] word,
    output logic          buf_ld,
    output logic          reg_st,
    output logic          add_en,
    output add_fn_e       add_fn,
    output logic          add_to_c,
    output logic          cnt_en,
    output logic          cnt_up,
    output logic          cmp_en,
    output logic          cmp_ab,
    output logic          jmp,
    output logic          modreq,
    output logic          halt,
    output logic          lev,
    output logic          outp,
    output logic          tape,
    output logic          tog_wp,
    output logic          tog_bank,
    output logic          tog_io
);
    logic [2:0] cls;
    logic [2:0] arg;
    logic       reg_code_ok;

    assign cls = word[5:3];
    assign arg = word[2:0];
    // register argument codes that name a storage element
    assign reg_code_ok = (arg == 3'b001) || (arg == 3'b010) || (arg == 3'b011)
                      || (arg == 3'b100) || (arg == 3'b110);

    // Decode class and argument into one-hot style controls.
    always_comb begin
        buf_ld = 1'b0; reg_st = 1'b0; add_en = 1'b0; add_fn = AF_NONE;
        add_to_c = 1'b0; cnt_en = 1'b0; cnt_up = 1'b0; cmp_en = 1'b0;
        cmp_ab = 1'b0; jmp = 1'b0; modreq = 1'b0; halt = 1'b0; lev = 1'b0;
        outp = 1'b0; tape = 1'b0; tog_wp = 1'b0; tog_bank = 1'b0; tog_io = 1'b0;
        case (cls_e'(cls))
            CL_LOAD:  buf_ld = reg_code_ok || (arg == 3'b000);
            CL_STORE: reg_st = reg_code_ok;
            CL_ADD: begin
                add_en = 1'b1;
                case (arg)
                    3'b000: add_fn = AF_AB;
                    3'b001: begin add_fn = AF_AB;   add_to_c = 1'b1; end
                    3'b100: add_fn = AF_PASS;
                    3'b110: add_fn = AF_XOR;
                    3'b010: add_fn = AF_BC;
                    3'b011: begin add_fn = AF_BC;   add_to_c = 1'b1; end
                    default: add_en = 1'b0;
                endcase
            end
            CL_CNT: begin
                cnt_en = (arg == 3'b100) || (arg == 3'b101);
                cnt_up = (arg == 3'b100);
            end
            CL_CMP: begin
                cmp_en = (arg == 3'b000) || (arg == 3'b011);
                cmp_ab = (arg == 3'b011);
            end
            CL_JMP: jmp = 1'b1;
            CL_MOD: modreq = 1'b1;
            CL_SYS: begin
                case (arg)
                    3'b000: lev      = 1'b1;
                    3'b001: outp     = 1'b1;
                    3'b010: tape     = 1'b1;
                    3'b100: tog_bank = 1'b1;
                    3'b101: tog_wp   = 1'b1;
                    3'b110: halt     = 1'b1;
                    3'b111: tog_io   = 1'b1;
                    default: ;
                endcase
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/seq6_datapath.sv
// Register file, buffer, adder and counter of the sequencer core.
// Updates only when exec is high; assumes at most one action is decoded.
module seq6_datapath
    import seq6_pkg::*;
#(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         exec,
    input  logic [2:0]   arg,
    input  logic         buf_ld,
    input  logic         st_en,
    input  logic         add_en,
    input  add_fn_e      add_fn,
    input  logic         add_to_c,
    input  logic         cnt_en,
    input  logic         cnt_up,
    input  logic         cmp_ab,
    input  logic         lev_take,
    input  logic [W-1:0] lev_data,
    input  logic         tape_take,
    input  logic [W-1:0] tape_data,
    output logic [W-1:0] buf_q,
    output logic         cnt_zero,
    output logic         cmp_true
);
    logic [W-1:0] ra, rb, rc, rd, rf;
    logic [W-1:0] sum;
    logic [W-1:0] d_next;
    logic [W-1:0] src;

    // Adder result for the selected mode, wrapping at W bits.
    always_comb begin
        case (add_fn)
            AF_AB:   sum = ra + rb;
            AF_PASS: sum = ra;
            AF_XOR:  sum = ra ^ rc;
            AF_BC:   sum = rb + rc;
            default: sum = '0;
        endcase
    end

    // Counter step and zero test used for the skip decision.
    assign d_next   = cnt_up ? rd + 1'b1 : rd - 1'b1;
    assign cnt_zero = (d_next == '0);

    // Unsigned strict compare for the selected pair.
    assign cmp_true = cmp_ab ? (ra > rb) : (rb > rc);

    // Buffer source selection by register code.
    always_comb begin
        case (arg)
            3'b001:  src = ra;
            3'b010:  src = rb;
            3'b011:  src = rc;
            3'b100:  src = rd;
            3'b110:  src = rf;
            default: src = '0;
        endcase
    end

    // Register and buffer update on an executed instruction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ra <= '0; rb <= '0; rc <= '0; rd <= '0; rf <= '0; buf_q <= '0;
        end else if (exec) begin
            if (buf_ld)    buf_q <= src;
            if (lev_take)  buf_q <= lev_data;
            if (tape_take) buf_q <= tape_data;
            if (st_en) begin
                case (arg)
                    3'b001:  ra <= buf_q;
                    3'b010:  rb <= buf_q;
                    3'b011:  rc <= buf_q;
                    3'b100:  rd <= buf_q;
                    3'b110:  rf <= buf_q;
                    default: ;
                endcase
            end
            if (add_en) begin
                if (add_to_c) rc <= sum;
                else          rb <= sum;
            end
            if (cnt_en) rd <= d_next;
        end
    end
endmodule

// File: rtl/seq6_flow.sv
// Next program index: absolute jump, skip-by-two or plain advance.
// Assumes an 8-position store so that index arithmetic wraps naturally.
module seq6_flow
    import seq6_pkg::*;
(
    input  logic [PW-1:0] pc,
    input  logic [2:0]    arg,
    input  logic          jmp,
    input  logic          cnt_en,
    input  logic          cnt_zero,
    input  logic          cmp_en,
    input  logic          cmp_true,
    output logic [PW-1:0] pc_next
);
    logic skip;

    // Skip after a count that reaches zero or a compare that fails.
    assign skip = (cnt_en && cnt_zero) || (cmp_en && !cmp_true);

    // Select jump target or sequential step.
    always_comb begin
        if (jmp)       pc_next = arg;
        else if (skip) pc_next = pc + PW'(2);
        else           pc_next = pc + PW'(1);
    end
endmodule

// File: rtl/seq6_core.sv
// Top of the six-bit sequencer: fetch state, status bits and external handshakes.
// Assumes pm_word reflects pm_addr in the same cycle and W >= 6.
module seq6_core
    import seq6_pkg::*;
#(
    parameter int W        = 6,
    parameter int BANK_OFS = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [PW-1:0] pm_addr,
    input  logic [IW-1:0] pm_word,
    output logic          pm_we,
    output logic [PW-1:0] pm_waddr,
    output logic [IW-1:0] pm_wdata,
    output logic          mod_req,
    output logic [MW-1:0] mod_num,
    input  logic          mod_done,
    output logic          lev_ready,
    input  logic          lev_valid,
    input  logic [W-1:0]  lev_data,
    output logic          tape_ready,
    input  logic          tape_valid,
    input  logic [W-1:0]  tape_data,
    output logic          out_valid,
    output logic [W-1:0]  out_data,
    output logic          out_alt,
    output logic          halted
);
    state_e        state;
    logic [PW-1:0] pc;
    logic [PW-1:0] pc_next;
    logic          wp_bit, bank_bit, io_bit;
    logic          run, stall, exec;
    logic [W-1:0]  buf_q;
    logic          cnt_zero, cmp_true;
    logic [2:0]    arg;

    logic          buf_ld, reg_st, add_en, add_to_c, cnt_en, cnt_up;
    logic          cmp_en, cmp_ab, jmp, modreq, halt, lev, outp, tape;
    logic          tog_wp, tog_bank, tog_io;
    add_fn_e       add_fn;

    assign arg = pm_word[2:0];

    seq6_decode u_dec (
        .word(pm_word), .buf_ld(buf_ld), .reg_st(reg_st), .add_en(add_en),
        .add_fn(add_fn), .add_to_c(add_to_c), .cnt_en(cnt_en), .cnt_up(cnt_up),
        .cmp_en(cmp_en), .cmp_ab(cmp_ab), .jmp(jmp), .modreq(modreq),
        .halt(halt), .lev(lev), .outp(outp), .tape(tape), .tog_wp(tog_wp),
        .tog_bank(tog_bank), .tog_io(tog_io)
    );

    // Execute gating: run state and any input handshake satisfied.
    assign run   = (state == ST_RUN);
    assign stall = (lev && !lev_valid) || (tape && !tape_valid);
    assign exec  = run && !stall;

    assign lev_ready  = run && lev;
    assign tape_ready = run && tape;

    seq6_datapath #(.W(W)) u_dp (
        .clk(clk), .rst_n(rst_n), .exec(exec), .arg(arg), .buf_ld(buf_ld),
        .st_en(reg_st && !wp_bit), .add_en(add_en), .add_fn(add_fn),
        .add_to_c(add_to_c), .cnt_en(cnt_en), .cnt_up(cnt_up), .cmp_ab(cmp_ab),
        .lev_take(lev), .lev_data(lev_data), .tape_take(tape),
        .tape_data(tape_data), .buf_q(buf_q), .cnt_zero(cnt_zero),
        .cmp_true(cmp_true)
    );

    seq6_flow u_flow (
        .pc(pc), .arg(arg), .jmp(jmp), .cnt_en(cnt_en), .cnt_zero(cnt_zero),
        .cmp_en(cmp_en), .cmp_true(cmp_true), .pc_next(pc_next)
    );

    // Redirected store path into the program store.
    assign pm_we    = exec && reg_st && wp_bit;
    assign pm_waddr = arg;
    assign pm_wdata = buf_q[IW-1:0];

    // Control state and program index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_RUN;
            pc    <= '0;
        end else begin
            case (state)
                ST_RUN: begin
                    if (exec) begin
                        if (halt)        state <= ST_HALT;
                        else if (modreq) state <= ST_MODW;
                        else             pc    <= pc_next;
                    end
                end
                ST_MODW: begin
                    if (mod_done) begin
                        state <= ST_RUN;
                        pc    <= '0;
                    end
                end
                default: ;
            endcase
        end
    end

    // Status bits toggled by system commands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp_bit <= 1'b0; bank_bit <= 1'b0; io_bit <= 1'b0;
        end else if (exec) begin
            if (tog_wp)   wp_bit   <= !wp_bit;
            if (tog_bank) bank_bit <= !bank_bit;
            if (tog_io)   io_bit   <= !io_bit;
        end
    end

    // Module number latched when a load request executes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mod_num <= '0;
        end else if (exec && modreq) begin
            mod_num <= MW'(arg) + MW'(1) + (bank_bit ? MW'(BANK_OFS) : MW'(0));
        end
    end

    // Registered output strobe with buffer value and I/O bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0; out_data <= '0; out_alt <= 1'b0;
        end else begin
            out_valid <= exec && outp;
            if (exec && outp) begin
                out_data <= buf_q;
                out_alt  <= io_bit;
            end
        end
    end

    assign pm_addr = pc;
    assign mod_req = (state == ST_MODW);
    assign halted  = (state == ST_HALT);
endmodule

// File: rtl/seq6_core_chk.sv
// Protocol checker for seq6_core: halt, module wait and input hold rules.
// Observes ports only; attached to every seq6_core instance by bind.
module seq6_core_chk
    import seq6_pkg::*;
(
    input logic          clk,
    input logic          rst_n,
    input logic          halted,
    input logic          mod_req,
    input logic          mod_done,
    input logic [MW-1:0] mod_num,
    input logic [PW-1:0] pm_addr,
    input logic          lev_ready,
    input logic          lev_valid,
    input logic          tape_ready,
    input logic          tape_valid,
    input logic          pm_we
);
    p_halt_sticky_r13: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);

    p_halt_quiet_r13: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> (!mod_req && !lev_ready && !tape_ready && !pm_we));

    p_mod_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mod_req && !mod_done) |=> (mod_req && $stable(mod_num) && $stable(pm_addr)));

    p_mod_resume_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mod_req && mod_done) |=> (!mod_req && pm_addr == '0));

    p_lev_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (lev_ready && !lev_valid) |=> $stable(pm_addr));

    p_tape_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (tape_ready && !tape_valid) |=> $stable(pm_addr));
endmodule

bind seq6_core seq6_core_chk u_chk (
    .clk(clk), .rst_n(rst_n), .halted(halted), .mod_req(mod_req),
    .mod_done(mod_done), .mod_num(mod_num), .pm_addr(pm_addr),
    .lev_ready(lev_ready), .lev_valid(lev_valid), .tape_ready(tape_ready),
    .tape_valid(tape_valid), .pm_we(pm_we)
);

// File: tb/seq6_core_tb.sv
// Bench for seq6_core: vector table of short programs, then directed tests.
module seq6_core_tb;
    localparam int W  = 6;
    localparam int NV = 14;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [2:0]   pm_addr;
    logic [5:0]   pm_word;
    logic         pm_we;
    logic [2:0]   pm_waddr;
    logic [5:0]   pm_wdata;
    logic         mod_req;
    logic [4:0]   mod_num;
    logic         mod_done = 1'b0;
    logic         lev_ready;
    logic         lev_valid = 1'b0;
    logic [W-1:0] lev_data = '0;
    logic         tape_ready;
    logic         tape_valid = 1'b0;
    logic [W-1:0] tape_data = '0;
    logic         out_valid;
    logic [W-1:0] out_data;
    logic         out_alt;
    logic         halted;

    logic [5:0]   mem [8];
    logic [W-1:0] obuf [8];
    logic         oalt [8];
    int           ocnt = 0;
    int           total = 0;
    int           fails = 0;
    int           ld_cnt = 0;

    always #5 clk = !clk;

    seq6_core #(.W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .pm_addr(pm_addr), .pm_word(pm_word),
        .pm_we(pm_we), .pm_waddr(pm_waddr), .pm_wdata(pm_wdata),
        .mod_req(mod_req), .mod_num(mod_num), .mod_done(mod_done),
        .lev_ready(lev_ready), .lev_valid(lev_valid), .lev_data(lev_data),
        .tape_ready(tape_ready), .tape_valid(tape_valid), .tape_data(tape_data),
        .out_valid(out_valid), .out_data(out_data), .out_alt(out_alt),
        .halted(halted)
    );

    assign pm_word = mem[pm_addr];

    // Program store model with redirected writes and a 3-cycle module loader.
    // Every module image is: INC, LDD, OUT, HALT...
    always @(posedge clk) begin
        if (pm_we) mem[pm_waddr] <= pm_wdata;
        if (!rst_n || !mod_req) begin
            ld_cnt   <= 0;
            mod_done <= 1'b0;
        end else begin
            ld_cnt   <= ld_cnt + 1;
            mod_done <= (ld_cnt == 2);
            if (mod_done) begin
                mem[0] <= 6'o34; mem[1] <= 6'o04; mem[2] <= 6'o71;
                for (int k = 3; k < 8; k++) mem[k] <= 6'o76;
            end
        end
    end

    // Capture output strobes away from the clock edge.
    always @(negedge clk) begin
        if (out_valid && ocnt < 8) begin
            obuf[ocnt] = out_data;
            oalt[ocnt] = out_alt;
            ocnt = ocnt + 1;
        end
    end

    task automatic check(input logic ok, input string req, input int act, input int exp);
        total = total + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic start(input logic [47:0] prog);
        rst_n = 1'b0;
        lev_valid = 1'b0;
        tape_valid = 1'b0;
        for (int k = 0; k < 8; k++) mem[k] = prog[k*6 +: 6];
        repeat (2) @(negedge clk);
        ocnt = 0;
        rst_n = 1'b1;
    endtask

    task automatic wait_halt(input int lim);
        for (int k = 0; k < lim && !halted; k++) @(negedge clk);
    endtask

    // {req[3:0], program w7..w0 [47:0], lever value [5:0], expected output [5:0]}
    localparam logic [63:0] VEC [NV] = '{
        // R2: A+B->C
        {4'd2, {6'o76,6'o76,6'o71,6'o03,6'o21,6'o12,6'o11,6'o70}, 6'd5,  6'd10},
        // R2: A+B->C wraps modulo 64
        {4'd2, {6'o76,6'o76,6'o71,6'o03,6'o21,6'o12,6'o11,6'o70}, 6'd40, 6'd16},
        // R2: copy A->B, A+B->C, A^C->B
        {4'd2, {6'o76,6'o71,6'o02,6'o26,6'o21,6'o24,6'o11,6'o70}, 6'd5,  6'd15},
        {4'd2, {6'o76,6'o71,6'o02,6'o26,6'o21,6'o24,6'o11,6'o70}, 6'd3,  6'd5},
        // R2: B+C->B then B+C->C
        {4'd2, {6'o76,6'o71,6'o03,6'o23,6'o22,6'o13,6'o12,6'o70}, 6'd7,  6'd21},
        // R3: decrement to zero skips the store to A
        {4'd3, {6'o76,6'o76,6'o71,6'o01,6'o11,6'o35,6'o14,6'o70}, 6'd1,  6'd0},
        // R3: decrement to nonzero runs the store
        {4'd3, {6'o76,6'o76,6'o71,6'o01,6'o11,6'o35,6'o14,6'o70}, 6'd2,  6'd2},
        // R3: increment wrapping 63->0 skips
        {4'd3, {6'o76,6'o76,6'o71,6'o01,6'o11,6'o34,6'o14,6'o70}, 6'd63, 6'd0},
        // R4: B>C true runs next
        {4'd4, {6'o76,6'o76,6'o71,6'o01,6'o11,6'o40,6'o12,6'o70}, 6'd9,  6'd9},
        // R4: B>C false skips next
        {4'd4, {6'o76,6'o76,6'o71,6'o01,6'o11,6'o40,6'o13,6'o70}, 6'd9,  6'd0},
        // R4: A>B with equal values is false
        {4'd4, {6'o76,6'o71,6'o03,6'o13,6'o43,6'o12,6'o11,6'o70}, 6'd4,  6'd0},
        // R5: jump to index 4 passes over the halt at index 3
        {4'd5, {6'o76,6'o71,6'o06,6'o16,6'o76,6'o11,6'o54,6'o70}, 6'd12, 6'd12},
        // R1: zero load then load from D
        {4'd1, {6'o76,6'o76,6'o76,6'o71,6'o04,6'o00,6'o14,6'o70}, 6'd17, 6'd17},
        // R1: load with arg 101 leaves the buffer
        {4'd1, {6'o76,6'o76,6'o76,6'o76,6'o71,6'o05,6'o11,6'o70}, 6'd22, 6'd22}
    };

    initial begin
        #(2_000_000);
        fails = fails + 1;
        total = total + 1;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        // R14: reset state
        start({6'o76,6'o76,6'o76,6'o76,6'o76,6'o76,6'o76,6'o73});
        rst_n = 1'b0;
        @(negedge clk);
        check(pm_addr == 0 && !halted && !mod_req && !out_valid, "R14 reset state",
              {pm_addr, halted, mod_req, out_valid}, 0);
        rst_n = 1'b1;

        // Vector table walk
        for (int i = 0; i < NV; i++) begin
            logic [63:0] v;
            v = VEC[i];
            start(v[59:12]);
            lev_data = v[11:6];
            lev_valid = 1'b1;
            wait_halt(100);
            check(ocnt >= 1 && obuf[0] == v[5:0],
                  $sformatf("R%0d vector %0d", v[63:60], i),
                  (ocnt >= 1) ? int'(obuf[0]) : -1, int'(v[5:0]));
        end

        // R13: halt holds
        start({6'o71,6'o71,6'o71,6'o71,6'o71,6'o71,6'o71,6'o76});
        repeat (12) @(negedge clk);
        check(halted && pm_addr == 0 && ocnt == 0, "R13 halt holds",
              {halted, pm_addr, 4'(ocnt)}, 8'h80);

        // R9: lever wait holds the index
        start({6'o76,6'o76,6'o76,6'o76,6'o71,6'o01,6'o11,6'o70});
        repeat (5) @(negedge clk);
        check(lev_ready && pm_addr == 0, "R9 lever wait", {lev_ready, pm_addr}, 8);
        lev_data = 6'd33; lev_valid = 1'b1;
        @(negedge clk);
        lev_valid = 1'b0;
        wait_halt(50);
        check(ocnt == 1 && obuf[0] == 33, "R9 lever value", int'(obuf[0]), 33);

        // R10: tape wait holds the index
        start({6'o76,6'o76,6'o76,6'o76,6'o76,6'o76,6'o71,6'o72});
        repeat (4) @(negedge clk);
        check(tape_ready && pm_addr == 0, "R10 tape wait", {tape_ready, pm_addr}, 8);
        tape_data = 6'd21; tape_valid = 1'b1;
        @(negedge clk);
        tape_valid = 1'b0;
        wait_halt(50);
        check(ocnt == 1 && obuf[0] == 21, "R10 tape value", int'(obuf[0]), 21);

        // R7: module request, number, hold and restart at index 0
        start({6'o76,6'o76,6'o76,6'o76,6'o76,6'o76,6'o76,6'o62});
        repeat (2) @(negedge clk);
        check(mod_req && mod_num == 3, "R7 module number", int'(mod_num), 3);
        check(pm_addr == 0, "R7 index held", int'(pm_addr), 0);
        wait_halt(50);
        check(ocnt == 1 && obuf[0] == 1, "R7 resume at index 0", int'(obuf[0]), 1);

        // R8: bank bit adds 8
        start({6'o76,6'o76,6'o76,6'o76,6'o76,6'o76,6'o60,6'o74});
        repeat (3) @(negedge clk);
        check(mod_req && mod_num == 9, "R8 bank offset", int'(mod_num), 9);
        wait_halt(50);

        // R12: redirected store rewrites index 3 with OUT (57), C untouched
        start({6'o76,6'o76,6'o71,6'o03,6'o76,6'o13,6'o70,6'o75});
        lev_data = 6'd57; lev_valid = 1'b1;
        wait_halt(50);
        check(ocnt >= 1 && obuf[0] == 57, "R12 program rewrite", int'(obuf[0]), 57);
        check(ocnt == 2 && obuf[1] == 0, "R12 C unchanged", int'(obuf[1]), 0);

        // R6: no halt, wraps 7->0 and repeats
        start({6'o73,6'o73,6'o73,6'o73,6'o73,6'o71,6'o04,6'o34});
        repeat (30) @(negedge clk);
        check(ocnt >= 2 && obuf[0] == 1 && obuf[1] == 2, "R6 wrap",
              int'(obuf[1]), 2);

        // R11: I/O bit travels with a single strobe
        start({6'o76,6'o76,6'o76,6'o76,6'o76,6'o76,6'o71,6'o77});
        wait_halt(50);
        repeat (3) @(negedge clk);
        check(ocnt == 1 && oalt[0] == 1'b1 && obuf[0] == 0, "R11 output strobe",
              ocnt, 1);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule